// File: doc/BRIEF.md
# Dual-Lane Framed Pixel Serializer

This block turns a stream of 32-bit words from a transmit FIFO into a framed serial transmission on two data lanes. Each word carries two 14-bit pixels. Each pixel goes out as one symbol that lasts seven clock cycles. The low seven bits of the pixel travel on lane 0 and the high seven bits on lane 1, both most significant bit first, at one bit per clock. The block also drives a marker on the first bit of every symbol and a sync line.

A sequencer builds the transmission out of periods, and every period length is a whole number of symbols. A frame is a preamble, then a sync period, then a programmed number of lines. Each line is a run of pixel symbols followed by an idle gap. After the last line the next frame starts at the preamble again. The preamble, sync and idle periods each send their own programmable 14-bit pattern. In data periods every pixel is XORed with a programmable data pattern before it is sent.

Nothing is sent until the FIFO holds a programmed minimum number of words. After that, a programmable number of idle symbols sets where the first frame starts. If the FIFO runs dry when a new word is needed, a sticky underrun flag is set. Idle symbols then fill the gap until the minimum fill is reached again, and the line resumes where it stopped.

Top module: `txf_top`

## Requirements
- R1: While `rst` is high at a clock edge, the lanes, `tx_sync`, `tx_sym`, `fifo_pop` and `underrun` are all 0 after that edge. The first symbol starts at the first clock edge after reset is released.
- R2: After reset the block sends the idle pattern and never pops until a symbol boundary at which `fifo_count >= cfg_start_min`. That boundary's symbol is still idle.
- R3: The start threshold is met at some symbol boundary. From the next symbol on, `cfg_lead_len` idle symbols are sent, and after them comes the first preamble symbol. A value of 0 means the preamble follows directly.
- R4: A frame is `cfg_pre_len` preamble symbols, then `cfg_sync_len` sync symbols, then `cfg_lines` lines. Each line is `cfg_line_len` pixel symbols followed by `cfg_idle_len` idle symbols. After the last line the next frame begins with the preamble. All of these lengths are at least 1.
- R5: Preamble, sync and idle symbols carry `pat_pre`, `pat_sync` and `pat_idle`. Waiting and lead symbols also carry `pat_idle`. A pixel symbol carries the pixel XOR `pat_data`.
- R6: Pixel 0 is word bits 13:0 and is sent first. Pixel 1 is word bits 29:16 of the same word. A word is popped once, at the boundary of its pixel 0 symbol, and the pixel 1 of a word is always sent before the next pop, even across a line boundary.
- R7: Symbol bits 6:0 go out on `tx_lane0` and bits 13:7 on `tx_lane1`, most significant bit first, one bit per clock, seven clocks per symbol.
- R8: `tx_sym` is high exactly on the first bit of each symbol. `tx_sync` is high for every bit of the sync-period symbols and low otherwise.
- R9: A pixel 0 symbol may be due while `fifo_count` is 0. In that case `underrun` is set and stays set until reset, an idle symbol is sent, and the line position is held. Idle symbols follow until a boundary with `fifo_count >= cfg_start_min`; that boundary's symbol is idle, and the held pixel comes next.
- R10: `fifo_pop` is never high while `fifo_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_min | input | CNT_W | FIFO words needed before start and after an underrun |
| cfg_lead_len | input | LEN_W | Idle symbols between start and the first preamble |
| cfg_pre_len | input | LEN_W | Preamble symbols per frame |
| cfg_sync_len | input | LEN_W | Sync symbols per frame |
| cfg_line_len | input | LEN_W | Pixel symbols per line |
| cfg_idle_len | input | LEN_W | Idle symbols after each line |
| cfg_lines | input | LEN_W | Lines per frame |
| pat_pre | input | 14 | Preamble symbol pattern |
| pat_sync | input | 14 | Sync symbol pattern |
| pat_data | input | 14 | XOR mask applied to every pixel |
| pat_idle | input | 14 | Idle symbol pattern |
| fifo_data | input | 32 | FIFO head word (show-ahead) |
| fifo_count | input | CNT_W | Words held in the FIFO |
| fifo_pop | output | 1 | Removes the head word at this clock edge |
| tx_lane0 | output | 1 | Serial lane for pixel bits 6:0 |
| tx_lane1 | output | 1 | Serial lane for pixel bits 13:7 |
| tx_sync | output | 1 | High during sync-period symbols |
| tx_sym | output | 1 | High on the first bit of each symbol |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
A wrong period or line counter shows up on the lanes within one symbol, seven clocks, as a pattern in the wrong slot or a frame of the wrong length. A wrong pixel-half flag shows up as swapped or repeated pixels. The bench sees this because it compares every symbol against the word it expects to have been popped. A stuck stall or threshold decision changes the run of idle symbols and the `underrun` flag, and it does so at the first symbol boundary after the FIFO empties or refills.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int PIX_W    = 14;
    localparam int SYM_W    = PIX_W / 2;
    localparam int WORD_W   = 32;
    localparam int PIX0_LSB = 0;
    localparam int PIX1_LSB = 16;
    localparam int LANES    = PIX_W / SYM_W;

    typedef enum logic [2:0] {
        PH_WAIT, PH_LEAD, PH_PRE, PH_SYNC, PH_DATA, PH_IDLE
    } phase_e;

    typedef enum logic [1:0] {
        SRC_IDLE, SRC_PRE, SRC_SYNC, SRC_PIX
    } src_e;

    function automatic logic [PIX_W-1:0] pick_pixel(
        input logic [WORD_W-1:0] w, input logic hi);
        return hi ? w[PIX1_LSB +: PIX_W] : w[PIX0_LSB +: PIX_W];
    endfunction

endpackage

// File: rtl/txf_seq.sv
module txf_seq
    import txf_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_start_min,
    input  logic [LEN_W-1:0] cfg_lead_len,
    input  logic [LEN_W-1:0] cfg_pre_len,
    input  logic [LEN_W-1:0] cfg_sync_len,
    input  logic [LEN_W-1:0] cfg_line_len,
    input  logic [LEN_W-1:0] cfg_idle_len,
    input  logic [LEN_W-1:0] cfg_lines,
    input  logic [CNT_W-1:0] fifo_count,
    output src_e             src,
    output logic             pix_hi,
    output logic             fifo_pop,
    output logic             underrun
);

    phase_e           ph_q, ph_d;
    logic [LEN_W-1:0] cnt_q, cnt_d, line_q, line_d;
    logic             half_q, half_d, stall_q, stall_d, und_q, und_d;
    logic             have_min, fifo_empty;

    always_comb begin
        have_min   = fifo_count >= cfg_start_min;
        fifo_empty = fifo_count == '0;
        ph_d       = ph_q;
        cnt_d      = cnt_q;
        line_d     = line_q;
        half_d     = half_q;
        stall_d    = stall_q;
        und_d      = und_q;
        src        = SRC_IDLE;
        fifo_pop   = 1'b0;
        case (ph_q)
            PH_WAIT: begin
                if (have_min) begin
                    ph_d  = (cfg_lead_len == '0) ? PH_PRE : PH_LEAD;
                    cnt_d = '0;
                end
            end
            PH_LEAD: begin
                if (cnt_q == cfg_lead_len - 1'b1) begin
                    ph_d  = PH_PRE;
                    cnt_d = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            PH_PRE: begin
                src = SRC_PRE;
                if (cnt_q == cfg_pre_len - 1'b1) begin
                    ph_d  = PH_SYNC;
                    cnt_d = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            PH_SYNC: begin
                src = SRC_SYNC;
                if (cnt_q == cfg_sync_len - 1'b1) begin
                    ph_d   = PH_DATA;
                    cnt_d  = '0;
                    line_d = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            PH_DATA: begin
                if (stall_q) begin
                    if (have_min) stall_d = 1'b0;
                end else if (!half_q && fifo_empty) begin
                    stall_d = 1'b1;
                    und_d   = 1'b1;
                end else begin
                    src      = SRC_PIX;
                    fifo_pop = load && !half_q;
                    half_d   = !half_q;
                    if (cnt_q == cfg_line_len - 1'b1) begin
                        ph_d  = PH_IDLE;
                        cnt_d = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                if (cnt_q == cfg_idle_len - 1'b1) begin
                    cnt_d = '0;
                    if (line_q == cfg_lines - 1'b1) begin
                        ph_d   = PH_PRE;
                        line_d = '0;
                    end else begin
                        ph_d   = PH_DATA;
                        line_d = line_q + 1'b1;
                    end
                end else cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_WAIT;
            cnt_q   <= '0;
            line_q  <= '0;
            half_q  <= 1'b0;
            stall_q <= 1'b0;
            und_q   <= 1'b0;
        end else if (load) begin
            ph_q    <= ph_d;
            cnt_q   <= cnt_d;
            line_q  <= line_d;
            half_q  <= half_d;
            stall_q <= stall_d;
            und_q   <= und_d;
        end
    end

    assign pix_hi   = half_q;
    assign underrun = und_q;

    // Tracking state for the checks below.
    logic armed_q, owe_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            owe_q   <= 1'b0;
        end else begin
            if (load && have_min) armed_q <= 1'b1;
            if (fifo_pop) owe_q <= 1'b1;
            else if (load && src == SRC_PIX && half_q) owe_q <= 1'b0;
        end
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_count != '0); // R10
    AST_POP_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> armed_q); // R2
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R9
    AST_PIX1_BEFORE_POP: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !owe_q); // R6

endmodule

// File: rtl/txf_unpack.sv
module txf_unpack
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_pop,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              pix_hi,
    input  src_e              src,
    input  logic [PIX_W-1:0]  pat_pre,
    input  logic [PIX_W-1:0]  pat_sync,
    input  logic [PIX_W-1:0]  pat_data,
    input  logic [PIX_W-1:0]  pat_idle,
    output logic [PIX_W-1:0]  sym_bits
);

    logic [WORD_W-1:0] word_q;
    logic [PIX_W-1:0]  pixel;

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else if (fifo_pop) word_q <= fifo_data;
    end

    // Pixel 0 comes straight from the FIFO head; pixel 1 from the held word.
    assign pixel = pix_hi ? pick_pixel(word_q, 1'b1) : pick_pixel(fifo_data, 1'b0);

    always_comb begin
        case (src)
            SRC_PRE:  sym_bits = pat_pre;
            SRC_SYNC: sym_bits = pat_sync;
            SRC_PIX:  sym_bits = pixel ^ pat_data;
            default:  sym_bits = pat_idle;
        endcase
    end

endmodule

// File: rtl/txf_lane_ser.sv
module txf_lane_ser
    import txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SYM_W-1:0] sym,
    output logic             bit_out
);

    logic [SYM_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else if (load) sh_q <= sym;
        else sh_q <= {sh_q[SYM_W-2:0], 1'b0};
    end

    assign bit_out = sh_q[SYM_W-1];

endmodule

// File: rtl/txf_top.sv
module txf_top
    import txf_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_start_min,
    input  logic [LEN_W-1:0]  cfg_lead_len,
    input  logic [LEN_W-1:0]  cfg_pre_len,
    input  logic [LEN_W-1:0]  cfg_sync_len,
    input  logic [LEN_W-1:0]  cfg_line_len,
    input  logic [LEN_W-1:0]  cfg_idle_len,
    input  logic [LEN_W-1:0]  cfg_lines,
    input  logic [PIX_W-1:0]  pat_pre,
    input  logic [PIX_W-1:0]  pat_sync,
    input  logic [PIX_W-1:0]  pat_data,
    input  logic [PIX_W-1:0]  pat_idle,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_pop,
    output logic              tx_lane0,
    output logic              tx_lane1,
    output logic              tx_sync,
    output logic              tx_sym,
    output logic              underrun
);

    localparam int BC_W = $clog2(SYM_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(SYM_W - 1);

    logic [BC_W-1:0]  bit_cnt_q;
    logic             sym_load, pix_hi;
    src_e             src;
    logic [PIX_W-1:0] sym_bits;
    logic [LANES-1:0] lane_bits;

    assign sym_load = bit_cnt_q == BC_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt_q <= BC_LAST;
            tx_sync   <= 1'b0;
            tx_sym    <= 1'b0;
        end else begin
            bit_cnt_q <= sym_load ? '0 : bit_cnt_q + 1'b1;
            tx_sym    <= sym_load;
            if (sym_load) tx_sync <= src == SRC_SYNC;
        end
    end

    txf_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .load(sym_load),
        .cfg_start_min(cfg_start_min), .cfg_lead_len(cfg_lead_len),
        .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len),
        .cfg_line_len(cfg_line_len), .cfg_idle_len(cfg_idle_len),
        .cfg_lines(cfg_lines), .fifo_count(fifo_count),
        .src(src), .pix_hi(pix_hi), .fifo_pop(fifo_pop), .underrun(underrun)
    );

    txf_unpack u_unpack (
        .clk(clk), .rst(rst), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
        .pix_hi(pix_hi), .src(src), .pat_pre(pat_pre), .pat_sync(pat_sync),
        .pat_data(pat_data), .pat_idle(pat_idle), .sym_bits(sym_bits)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        txf_lane_ser u_ser (
            .clk(clk), .rst(rst), .load(sym_load),
            .sym(sym_bits[g*SYM_W +: SYM_W]), .bit_out(lane_bits[g])
        );
    end

    assign tx_lane0 = lane_bits[0];
    assign tx_lane1 = lane_bits[1];

    AST_SYNC_HELD: assert property (@(posedge clk) disable iff (rst)
        !sym_load |=> $stable(tx_sync)); // R8
    AST_SYM_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_sym |=> !tx_sym); // R8
    AST_POP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> sym_load); // R6

endmodule

// File: tb/txf_top_tb.sv
module txf_top_tb;

    localparam int LEN_W = 12;
    localparam int CNT_W = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_start_min = '0;
    logic [LEN_W-1:0] cfg_lead_len = '0, cfg_pre_len = 12'd1, cfg_sync_len = 12'd1;
    logic [LEN_W-1:0] cfg_line_len = 12'd1, cfg_idle_len = 12'd1, cfg_lines = 12'd1;
    logic [13:0]      pat_pre = '0, pat_sync = '0, pat_data = '0, pat_idle = '0;
    logic [31:0]      fifo_data;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_pop, tx_lane0, tx_lane1, tx_sync, tx_sym, underrun;

    txf_top #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (.*);

    int checks = 0;
    int errors = 0;

    // Bench FIFO
    logic [31:0] mem [0:1023];
    int wr_ptr = 0, rd_ptr = 0, last_cnt = 0;
    int push_limit = 0, push_pct = 0;
    assign fifo_count = CNT_W'(wr_ptr - rd_ptr);
    assign fifo_data  = mem[rd_ptr % 1024];

    always @(posedge clk) begin
        last_cnt <= wr_ptr - rd_ptr;
        if (rst) rd_ptr <= 0;
        else if (fifo_pop) rd_ptr <= rd_ptr + 1;
    end

    always @(negedge clk) begin
        if (rst) wr_ptr = 0;
        else if (wr_ptr < push_limit && wr_ptr < 1000 && ($urandom % 100) < push_pct) begin
            mem[wr_ptr % 1024] = $urandom;
            wr_ptr = wr_ptr + 1;
        end
    end

    // Symbol-level reference model
    int m_ph, m_cnt, m_line, m_mrd;
    bit m_half, m_stall, m_und;
    logic [31:0] m_word;
    logic [13:0] exp_bits;
    bit exp_sync, have_sym, sync_bad;
    string tag;
    logic [6:0] c0, c1;
    int nb;

    task automatic model_step(input int c);
        logic [13:0] pix;
        exp_sync = 0;
        exp_bits = pat_idle;
        case (m_ph)
            0: begin
                tag = "R2";
                if (c >= int'(cfg_start_min)) begin
                    m_ph = (cfg_lead_len == 0) ? 2 : 1;
                    m_cnt = 0;
                end
            end
            1: begin
                tag = "R3";
                if (m_cnt == int'(cfg_lead_len) - 1) begin m_ph = 2; m_cnt = 0; end
                else m_cnt++;
            end
            2: begin
                tag = "R4 R5 preamble";
                exp_bits = pat_pre;
                if (m_cnt == int'(cfg_pre_len) - 1) begin m_ph = 3; m_cnt = 0; end
                else m_cnt++;
            end
            3: begin
                tag = "R4 R5 sync";
                exp_bits = pat_sync;
                exp_sync = 1;
                if (m_cnt == int'(cfg_sync_len) - 1) begin m_ph = 4; m_cnt = 0; m_line = 0; end
                else m_cnt++;
            end
            4: begin
                if (m_stall) begin
                    tag = "R9 stall";
                    if (c >= int'(cfg_start_min)) m_stall = 0;
                end else if (!m_half && c == 0) begin
                    tag = "R9 underrun";
                    m_und = 1;
                    m_stall = 1;
                end else begin
                    tag = "R5 R6 R7 pixel";
                    if (!m_half) begin
                        m_word = mem[m_mrd % 1024];
                        m_mrd++;
                        pix = m_word[13:0];
                    end else pix = m_word[29:16];
                    m_half = !m_half;
                    exp_bits = pix ^ pat_data;
                    if (m_cnt == int'(cfg_line_len) - 1) begin m_ph = 5; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            default: begin
                tag = "R4 R5 idle";
                if (m_cnt == int'(cfg_idle_len) - 1) begin
                    m_cnt = 0;
                    if (m_line == int'(cfg_lines) - 1) begin m_ph = 2; m_line = 0; end
                    else begin m_ph = 4; m_line++; end
                end else m_cnt++;
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_line = 0; m_mrd = 0;
            m_half = 0; m_stall = 0; m_und = 0;
            have_sym = 0; nb = 0; sync_bad = 0;
        end else begin
            if (fifo_pop && fifo_count == 0) begin
                checks++; errors++;
                $display("FAIL R10 pop with empty fifo: pop=%0b expected 0", fifo_pop);
            end
            if (tx_sym) begin
                if (have_sym) begin
                    checks++;
                    if (nb != 7) begin
                        errors++;
                        $display("FAIL R8 symbol length actual %0d expected 7", nb);
                    end
                    checks++;
                    if ({c1, c0} !== exp_bits) begin
                        errors++;
                        $display("FAIL %s lanes actual %h expected %h", tag, {c1, c0}, exp_bits);
                    end
                    checks++;
                    if (sync_bad) begin
                        errors++;
                        $display("FAIL R8 tx_sync actual %0b expected %0b", !exp_sync, exp_sync);
                    end
                end
                model_step(last_cnt);
                have_sym = 1; nb = 0; sync_bad = 0;
                checks++;
                if (underrun !== m_und) begin
                    errors++;
                    $display("FAIL R9 underrun actual %0b expected %0b", underrun, m_und);
                end
            end
            if (have_sym) begin
                c0 = {c0[5:0], tx_lane0};
                c1 = {c1[5:0], tx_lane1};
                nb++;
                if (tx_sync !== exp_sync) sync_bad = 1;
            end
        end
    end

    task automatic start_phase(input int thr, input int lead, input int pre, input int syn,
                               input int line, input int idle, input int lines,
                               input int plim, input int ppct);
        @(negedge clk);
        rst = 1;
        cfg_start_min = CNT_W'(thr);
        cfg_lead_len = LEN_W'(lead);
        cfg_pre_len = LEN_W'(pre);
        cfg_sync_len = LEN_W'(syn);
        cfg_line_len = LEN_W'(line);
        cfg_idle_len = LEN_W'(idle);
        cfg_lines = LEN_W'(lines);
        pat_pre = 14'($urandom);
        pat_sync = 14'($urandom);
        pat_data = 14'($urandom);
        pat_idle = 14'($urandom);
        push_limit = plim;
        push_pct = ppct;
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if ({tx_lane0, tx_lane1, tx_sync, tx_sym, fifo_pop, underrun} !== 6'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b expected 000000",
                     {tx_lane0, tx_lane1, tx_sync, tx_sym, fifo_pop, underrun});
        end
        rst = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R2: threshold never reached, only idle, no pops
        start_phase(3, 1, 1, 1, 2, 1, 1, 2, 100);
        repeat (40 * 7) @(negedge clk);
        // R9: underrun then refill
        start_phase(2, 1, 1, 2, 6, 1, 2, 3, 100);
        repeat (80 * 7) @(negedge clk);
        push_limit = 40;
        push_pct = 30;
        repeat (120 * 7) @(negedge clk);
        // Minimal lengths, zero threshold and zero lead (R3, R4)
        start_phase(0, 0, 1, 1, 1, 1, 1, 1000, 100);
        repeat (60 * 7) @(negedge clk);
        // Odd line length across line boundary (R6)
        start_phase(1, 2, 2, 1, 3, 2, 3, 1000, 100);
        repeat (80 * 7) @(negedge clk);
        // Constrained random frames
        for (int p = 0; p < 5; p++) begin
            start_phase($urandom % 6, $urandom % 4, 1 + $urandom % 3, 1 + $urandom % 3,
                        1 + $urandom % 5, 1 + $urandom % 3, 1 + $urandom % 3, 1000, 12);
            repeat (280 * 7) @(negedge clk);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule